// File: doc/BRIEF.md
# DSP Address Pointer Update Unit

This block holds the two address pointers of a small fixed-point signal processor: the data-RAM pointer and the coefficient-ROM pointer. At the end of every arithmetic instruction it moves both pointers according to three instruction fields. A 2-bit code steps the lowest four bits of the RAM pointer up or down, clears them, or leaves them alone. The step wraps inside those four bits. A 4-bit mask is then XORed into the next four bits. A single bit lowers the ROM pointer by one.

A move in the same instruction can load either pointer. The load is applied first, and the step, the XOR and the decrement then act on the loaded value. Both pointers are registered, drive the memory address ports directly, and reset to zero. Two flags tell the branch unit whether the low four bits of the RAM pointer are all zeros or all ones. The pointer widths are parameters, for example 8 or 11 bits for the RAM pointer and 10 or 11 bits for the ROM pointer.

Top module: `dsp_ptr_update`

## Requirements
- R1: While `rst_n` is low, `dp_addr` and `rp_addr` are zero; `dpl_zero` is 1 and `dpl_full` is 0.
- R2: With `op_valid`=1 and `dpl_mode`=0, bits [3:0] of the RAM pointer keep their value, and bits above [7:4] are never changed by any mode.
- R3: With `op_valid`=1 and `dpl_mode`=1, bits [3:0] count up by one modulo 16. 15 becomes 0 with no carry into bit 4.
- R4: With `op_valid`=1 and `dpl_mode`=2, bits [3:0] count down by one modulo 16. 0 becomes 15 with no borrow from bit 4.
- R5: With `op_valid`=1 and `dpl_mode`=3, bits [3:0] become 0.
- R6: With `op_valid`=1, bits [7:4] of the RAM pointer are XORed with `dph_mask`, after the low-field step.
- R7: With `op_valid`=1 and `rp_dec`=1, the ROM pointer decreases by one and wraps from 0 to all ones at its width.
- R8: When `dp_load` or `rp_load` is 1, the low bits of `ld_val` replace that pointer first. The modify of R2 to R7 is then applied to the loaded value in the same cycle.
- R9: `dpl_zero` is 1 exactly when `dp_addr[3:0]` is 0, and `dpl_full` is 1 exactly when `dp_addr[3:0]` is 15.
- R10: With `op_valid`=0, `dpl_mode`, `dph_mask` and `rp_dec` have no effect. A pointer without a load holds its value, and a load still takes effect unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An arithmetic instruction completes this cycle |
| dpl_mode | input | 2 | Low-field code: 0 keep, 1 up, 2 down, 3 clear |
| dph_mask | input | 4 | XOR mask for RAM pointer bits [7:4] |
| rp_dec | input | 1 | Decrement the ROM pointer |
| dp_load | input | 1 | Load the RAM pointer from ld_val |
| rp_load | input | 1 | Load the ROM pointer from ld_val |
| ld_val | input | LD_W | Value from the move stage |
| dp_addr | output | DP_W | Current RAM pointer |
| rp_addr | output | RP_W | Current ROM pointer |
| dpl_zero | output | 1 | dp_addr[3:0] == 0 |
| dpl_full | output | 1 | dp_addr[3:0] == 15 |

## Verification
Every pointer result appears one rising edge after the inputs that cause it, because each pointer passes through exactly one register. The two flags are decoded without a register from the pointer, so they change in that same cycle. The bench drives inputs on the falling edge and compares the outputs on the next falling edge, after the single rising edge that applies them. It starts from the reset value and walks a chain of vectors that cross the 15-to-0 and 0-to-15 boundaries, wrap the ROM pointer, and combine a load with a modify.

// File: rtl/dsp_ptr_pkg.sv
package dsp_ptr_pkg;
    localparam int unsigned LOW_W  = 4;
    localparam int unsigned MASK_W = 4;

    typedef enum logic [1:0] {
        DPL_KEEP  = 2'd0,
        DPL_UP    = 2'd1,
        DPL_DOWN  = 2'd2,
        DPL_CLEAR = 2'd3
    } dpl_mode_e;
endpackage

// File: rtl/dsp_dp_unit.sv
module dsp_dp_unit
    import dsp_ptr_pkg::*;
#(
    parameter int unsigned DP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          mode,
    input  logic [MASK_W-1:0]   mask,
    input  logic                load,
    input  logic [DP_W-1:0]     load_val,
    output logic [DP_W-1:0]     dp,
    output logic                low_zero,
    output logic                low_full
);
    localparam int unsigned HI_LSB = LOW_W;
    localparam int unsigned HI_MSB = LOW_W + MASK_W - 1;

    typedef struct packed {
        logic [DP_W-1:0] ptr;
    } dp_state_t;

    dp_state_t st_d, st_q;
    logic [DP_W-1:0]  base;
    logic [LOW_W-1:0] low_nxt;

    always_comb begin
        base = load ? load_val : st_q.ptr;
        unique case (dpl_mode_e'(mode))
            DPL_UP:    low_nxt = base[LOW_W-1:0] + LOW_W'(1);
            DPL_DOWN:  low_nxt = base[LOW_W-1:0] - LOW_W'(1);
            DPL_CLEAR: low_nxt = '0;
            default:   low_nxt = base[LOW_W-1:0];
        endcase
        st_d.ptr = base;
        if (op_valid) begin
            st_d.ptr[LOW_W-1:0]     = low_nxt;
            st_d.ptr[HI_MSB:HI_LSB] = base[HI_MSB:HI_LSB] ^ mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dp       = st_q.ptr;
    assign low_zero = (st_q.ptr[LOW_W-1:0] == '0);
    assign low_full = (st_q.ptr[LOW_W-1:0] == '1);
endmodule

// File: rtl/dsp_rp_unit.sv
module dsp_rp_unit #(
    parameter int unsigned RP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             dec,
    input  logic             load,
    input  logic [RP_W-1:0]  load_val,
    output logic [RP_W-1:0]  rp
);
    typedef struct packed {
        logic [RP_W-1:0] ptr;
    } rp_state_t;

    rp_state_t st_d, st_q;
    logic [RP_W-1:0] base;

    always_comb begin
        base     = load ? load_val : st_q.ptr;
        st_d.ptr = (op_valid && dec) ? base - RP_W'(1) : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rp = st_q.ptr;
endmodule

// File: rtl/dsp_ptr_update.sv
module dsp_ptr_update
    import dsp_ptr_pkg::*;
#(
    parameter int unsigned DP_W = 8,
    parameter int unsigned RP_W = 10,
    parameter int unsigned LD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         dpl_mode,
    input  logic [MASK_W-1:0]  dph_mask,
    input  logic               rp_dec,
    input  logic               dp_load,
    input  logic               rp_load,
    input  logic [LD_W-1:0]    ld_val,
    output logic [DP_W-1:0]    dp_addr,
    output logic [RP_W-1:0]    rp_addr,
    output logic               dpl_zero,
    output logic               dpl_full
);
    dsp_dp_unit #(.DP_W(DP_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .mode     (dpl_mode),
        .mask     (dph_mask),
        .load     (dp_load),
        .load_val (ld_val[DP_W-1:0]),
        .dp       (dp_addr),
        .low_zero (dpl_zero),
        .low_full (dpl_full)
    );

    dsp_rp_unit #(.RP_W(RP_W)) u_rp (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .dec      (rp_dec),
        .load     (rp_load),
        .load_val (ld_val[RP_W-1:0]),
        .rp       (rp_addr)
    );
endmodule

// File: rtl/dsp_ptr_update_chk.sv
module dsp_ptr_update_chk #(
    parameter int unsigned DP_W = 8,
    parameter int unsigned RP_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       dpl_mode,
    input logic [3:0]       dph_mask,
    input logic             rp_dec,
    input logic             dp_load,
    input logic             rp_load,
    input logic [DP_W-1:0]  dp_addr,
    input logic [RP_W-1:0]  rp_addr,
    input logic             dpl_zero
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !dp_load && !rp_load) |=> ($stable(dp_addr) && $stable(rp_addr))); // R10

    AST_LOW_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dp_load && dpl_mode == 2'd1)
            |=> (dp_addr[3:0] == 4'($past(dp_addr[3:0]) + 4'd1))); // R3

    AST_LOW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dp_load && dpl_mode == 2'd2)
            |=> (dp_addr[3:0] == 4'($past(dp_addr[3:0]) - 4'd1))); // R4

    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dpl_mode == 2'd3) |=> dpl_zero); // R5

    AST_HIGH_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dp_load)
            |=> (dp_addr[7:4] == ($past(dp_addr[7:4]) ^ $past(dph_mask)))); // R6

    AST_RP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && rp_dec && !rp_load)
            |=> (rp_addr == RP_W'($past(rp_addr) - RP_W'(1)))); // R7
endmodule

bind dsp_ptr_update dsp_ptr_update_chk #(.DP_W(DP_W), .RP_W(RP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .dpl_mode (dpl_mode),
    .dph_mask (dph_mask),
    .rp_dec   (rp_dec),
    .dp_load  (dp_load),
    .rp_load  (rp_load),
    .dp_addr  (dp_addr),
    .rp_addr  (rp_addr),
    .dpl_zero (dpl_zero)
);

// File: tb/dsp_ptr_update_bench.sv
module dsp_ptr_update_bench;
    localparam int DP_W = 8;
    localparam int RP_W = 10;
    localparam int LD_W = 16;
    localparam int NVEC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] dpl_mode = '0;
    logic [3:0] dph_mask = '0;
    logic rp_dec = 1'b0, dp_load = 1'b0, rp_load = 1'b0;
    logic [LD_W-1:0] ld_val = '0;
    logic [DP_W-1:0] dp_addr;
    logic [RP_W-1:0] rp_addr;
    logic dpl_zero, dpl_full;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dsp_ptr_update #(.DP_W(DP_W), .RP_W(RP_W), .LD_W(LD_W)) u_dsp_ptr_update (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dpl_mode(dpl_mode),
        .dph_mask(dph_mask), .rp_dec(rp_dec), .dp_load(dp_load), .rp_load(rp_load),
        .ld_val(ld_val), .dp_addr(dp_addr), .rp_addr(rp_addr),
        .dpl_zero(dpl_zero), .dpl_full(dpl_full)
    );

    // {valid, mode, mask, rp_dec, dp_load, rp_load, ld_val, exp_dp, exp_rp, tag}
    localparam logic [51:0] VEC [NVEC] = '{
        {1'b1, 2'd1, 4'h0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h01, 10'h3FF, 8'd7},  // R7 wrap
        {1'b1, 2'd2, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 10'h3FF, 8'd4},
        {1'b1, 2'd2, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h0F, 10'h3FF, 8'd4},  // R4 0->F
        {1'b1, 2'd1, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 10'h3FF, 8'd3},  // R3 F->0
        {1'b1, 2'd0, 4'hA, 1'b0, 1'b0, 1'b0, 16'h0000, 8'hA0, 10'h3FF, 8'd6},
        {1'b1, 2'd1, 4'hA, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h01, 10'h3FF, 8'd6},
        {1'b1, 2'd1, 4'h3, 1'b1, 1'b1, 1'b1, 16'h015E, 8'h6F, 10'h15D, 8'd8},  // R8
        {1'b1, 2'd3, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h60, 10'h15D, 8'd5},
        {1'b0, 2'd1, 4'hF, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h60, 10'h15D, 8'd10},
        {1'b0, 2'd2, 4'h5, 1'b1, 1'b1, 1'b0, 16'h003C, 8'h3C, 10'h15D, 8'd10},
        {1'b1, 2'd0, 4'h0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h3C, 10'h15C, 8'd2},
        {1'b1, 2'd1, 4'h0, 1'b0, 1'b1, 1'b0, 16'h002F, 8'h20, 10'h15C, 8'd8}   // R8 + R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_flags(input logic [DP_W-1:0] exp_dp);
        check("R9 dpl_zero", {31'd0, dpl_zero}, {31'd0, exp_dp[3:0] == 4'h0});
        check("R9 dpl_full", {31'd0, dpl_full}, {31'd0, exp_dp[3:0] == 4'hF});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 dp", 32'(dp_addr), 32'h0);
        check("R1 rp", 32'(rp_addr), 32'h0);
        check_flags('0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            {op_valid, dpl_mode, dph_mask, rp_dec, dp_load, rp_load, ld_val} = VEC[i][51:26];
            @(negedge clk);
            check($sformatf("R%0d vec %0d dp", VEC[i][7:0], i), 32'(dp_addr), 32'(VEC[i][25:18]));
            check($sformatf("R%0d vec %0d rp", VEC[i][7:0], i), 32'(rp_addr), 32'(VEC[i][17:8]));
            check_flags(VEC[i][25:18]);
        end

        // R2: mode 0 with zero mask keeps the whole pointer
        op_valid = 1'b1; dpl_mode = 2'd0; dph_mask = 4'h0;
        rp_dec = 1'b0; dp_load = 1'b1; rp_load = 1'b0; ld_val = 16'h00F7;
        @(negedge clk);
        dp_load = 1'b0;
        @(negedge clk);
        check("R2 keep", 32'(dp_addr), 32'hF7);

        // R4 + R6: decrement wraps without borrowing into the XORed field
        dpl_mode = 2'd2; dph_mask = 4'h1; dp_load = 1'b1; ld_val = 16'h0050;
        @(negedge clk);
        check("R4 no borrow", 32'(dp_addr), 32'h4F);
        check_flags(8'h4F);

        // R8: ROM pointer load of zero with decrement wraps to all ones
        dp_load = 1'b0; dpl_mode = 2'd0; dph_mask = 4'h0;
        rp_load = 1'b1; rp_dec = 1'b1; ld_val = 16'h0000;
        @(negedge clk);
        check("R8 rp load+dec", 32'(rp_addr), 32'h3FF);

        // R1: reset in mid-run clears both pointers
        op_valid = 1'b0; rp_load = 1'b0; rp_dec = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 dp rerst", 32'(dp_addr), 32'h0);
        check("R1 rp rerst", 32'(rp_addr), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule